// File: doc/BRIEF.md
# Character LCD Start-Up Sequencer

This block brings a character LCD controller out of power-up without any help from the host. After reset it waits for the panel supply to settle. It then wakes the controller with three identical wake-up commands, spaced by timed gaps. In narrow wiring it next switches the controller to a 4-bit interface. It finishes by sending the width, line, font, display and entry-mode setup, followed by display on. The busy flag cannot be read this early, so every pause is a fixed count of clock cycles.

Commands leave the block as a valid/ready stream toward a lower-level bus-cycle engine, which produces the enable strobes and the nibble split. Once the last settle pause has elapsed, `init_done` rises. From then on the same stream carries the host's own traffic unchanged.

A parameter chooses 4-bit or 8-bit wiring. Line count, font, cursor direction and display shift come in on plain configuration pins.

Top module: `lcd_init_seq`

## Requirements
- R1: While reset is held, `cmd_valid`, `init_done` and `host_ready` are low. After reset is released, exactly `W_POWER` cycles pass with `cmd_valid` low before the first command is offered.
- R2: The first three commands are each 0x30. The second is offered `W_GAP1` idle cycles after the first handshake, and the third `W_GAP2` idle cycles after the second. `cmd_half` is 1 on all three in 4-bit mode and 0 in 8-bit mode.
- R3: In 4-bit mode (`WIDTH4`=1) the command after the wake-ups is 0x20 with `cmd_half`=1. In 8-bit mode no half-width command is ever offered. A half-width command always has `cmd_data[3:0]`=0.
- R4: Next comes function set 0x20 with bit 4 = 1 for 8-bit and 0 for 4-bit, bit 3 = line count and bit 2 = font. From here on every command has `cmd_half`=0.
- R5: Next come, in order: display off 0x08, clear 0x01, entry mode 0x04 (bit 1 = increment, bit 0 = shift), and display on 0x0C. The pause after clear is `W_CLEAR` idle cycles. Every other pause from the third wake-up onward is `W_CMD`.
- R6: The four configuration pins are captured on the last cycle of the power-up wait. Any later change has no effect on the commands sent.
- R7: While `cmd_valid` is high and `cmd_ready` is low, the offered command stays valid and unchanged. Each pause is counted from the handshake cycle.
- R8: `init_done` rises `W_SETTLE` idle cycles after the display-on handshake, and it stays high until the next reset.
- R9: Before `init_done`, `host_ready` is low and host traffic never reaches the command port. After `init_done`, `cmd_valid`, `cmd_rs` and `cmd_data` follow the host inputs, `cmd_half` is 0, and `host_ready` follows `cmd_ready`.
- R10: Reset asserted at any point in the sequence restarts it from the power-up wait.
- R11: Every command the sequencer itself issues has `cmd_rs`=0 (instruction register).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_lines | input | 1 | Line-count bit for function set |
| cfg_font | input | 1 | Font bit for function set |
| cfg_incr | input | 1 | Address increment (1) or decrement (0) for entry mode |
| cfg_shift | input | 1 | Display shift on write for entry mode |
| host_valid | input | 1 | Host command/data offered |
| host_ready | output | 1 | Host item accepted (only after init) |
| host_rs | input | 1 | Host register select (0 instruction, 1 data) |
| host_data | input | 8 | Host byte |
| cmd_valid | output | 1 | Item offered to the bus-cycle engine |
| cmd_ready | input | 1 | Bus-cycle engine accepts the item |
| cmd_rs | output | 1 | Register select of the offered item |
| cmd_data | output | 8 | Byte of the offered item |
| cmd_half | output | 1 | 1: send only the upper nibble once; 0: send the whole byte |
| init_done | output | 1 | Start-up sequence complete; host owns the port |

## Verification
The embedded properties check on every cycle that a stalled command holds steady, that `init_done` never falls, that the host is blocked and the register select stays low during start-up, and that the captured configuration does not move. They also check that half-width items carry a zero low nibble and never appear in 8-bit wiring. Other behaviour needs the bench's scenarios. This covers the exact byte order in each width and the exact idle-cycle counts between handshakes under back-pressure. It also covers the effect of configuration changes made mid-sequence, the restart after a reset in the middle of the sequence, and the host pass-through once start-up is finished.

// File: rtl/lcd_init_pkg.sv
package lcd_init_pkg;

  typedef enum logic [1:0] {
    PH_POWER,
    PH_OFFER,
    PH_HOLD,
    PH_READY
  } phase_t;

  typedef struct packed {
    logic lines;
    logic font;
    logic incr;
    logic shift;
  } lcd_cfg_t;

  localparam int STEP_W = 4;
  typedef logic [STEP_W-1:0] step_t;

  // Step order is behaviour: the controller must see them in this sequence.
  localparam step_t ST_WAKE_A = 4'd0;
  localparam step_t ST_WAKE_B = 4'd1;
  localparam step_t ST_WAKE_C = 4'd2;
  localparam step_t ST_NARROW = 4'd3;
  localparam step_t ST_FUNC   = 4'd4;
  localparam step_t ST_DARK   = 4'd5;
  localparam step_t ST_WIPE   = 4'd6;
  localparam step_t ST_ENTRY  = 4'd7;
  localparam step_t ST_LIGHT  = 4'd8;

  localparam logic [7:0] OP_WAKE       = 8'h30;
  localparam logic [7:0] OP_NARROW     = 8'h20;
  localparam logic [7:0] OP_FUNC_BASE  = 8'h20;
  localparam logic [7:0] OP_DARK       = 8'h08;
  localparam logic [7:0] OP_WIPE       = 8'h01;
  localparam logic [7:0] OP_ENTRY_BASE = 8'h04;
  localparam logic [7:0] OP_LIGHT      = 8'h0C;

  function automatic int unsigned max_of(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/lcd_init_timer.sv
module lcd_init_timer #(
  parameter int            CW    = 8,
  parameter logic [CW-1:0] START = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          expired
);

  logic [CW-1:0] cnt;

  // Counts down to zero and rests there; reset preloads the power-up wait.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= START;
    end else if (load) begin
      cnt <= load_val;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign expired = (cnt == '0);

  AST_COUNT_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    (expired && !load) |=> expired); // R1

endmodule

// File: rtl/lcd_init_steps.sv
module lcd_init_steps
  import lcd_init_pkg::*;
#(
  parameter bit          WIDTH4   = 1'b1,
  parameter int          CW       = 8,
  parameter int unsigned W_GAP1   = 10,
  parameter int unsigned W_GAP2   = 4,
  parameter int unsigned W_CMD    = 2,
  parameter int unsigned W_CLEAR  = 6,
  parameter int unsigned W_SETTLE = 8
) (
  input  step_t          idx,
  input  lcd_cfg_t       cfg,
  output logic [7:0]     op,
  output logic           half,
  output logic [CW-1:0]  wait_val,
  output logic           last,
  output step_t          nxt
);

  localparam logic          WIDE_BIT = WIDTH4 ? 1'b0 : 1'b1;
  localparam logic          WAKE_HALF = WIDTH4 ? 1'b1 : 1'b0;
  localparam logic [CW-1:0] L_GAP1   = CW'(W_GAP1 - 1);
  localparam logic [CW-1:0] L_GAP2   = CW'(W_GAP2 - 1);
  localparam logic [CW-1:0] L_CMD    = CW'(W_CMD - 1);
  localparam logic [CW-1:0] L_CLEAR  = CW'(W_CLEAR - 1);
  localparam logic [CW-1:0] L_SETTLE = CW'(W_SETTLE - 1);

  // Byte, width flag and following pause for each step.
  always_comb begin
    op       = '0;
    half     = 1'b0;
    wait_val = L_CMD;
    last     = 1'b0;
    case (idx)
      ST_WAKE_A: begin op = OP_WAKE; half = WAKE_HALF; wait_val = L_GAP1; end
      ST_WAKE_B: begin op = OP_WAKE; half = WAKE_HALF; wait_val = L_GAP2; end
      ST_WAKE_C: begin op = OP_WAKE; half = WAKE_HALF; end
      ST_NARROW: begin op = OP_NARROW; half = 1'b1; end
      ST_FUNC:   op = OP_FUNC_BASE | {3'b000, WIDE_BIT, cfg.lines, cfg.font, 2'b00};
      ST_DARK:   op = OP_DARK;
      ST_WIPE:   begin op = OP_WIPE; wait_val = L_CLEAR; end
      ST_ENTRY:  op = OP_ENTRY_BASE | {6'b000000, cfg.incr, cfg.shift};
      ST_LIGHT:  begin op = OP_LIGHT; wait_val = L_SETTLE; last = 1'b1; end
      default:   last = 1'b1;
    endcase
  end

  // Narrow wiring walks every step; wide wiring skips the width switch.
  generate
    if (WIDTH4) begin : g_narrow_walk
      assign nxt = idx + step_t'(1);
    end else begin : g_wide_walk
      assign nxt = (idx == ST_WAKE_C) ? ST_FUNC : idx + step_t'(1);
    end
  endgenerate

endmodule

// File: rtl/lcd_init_arb.sv
module lcd_init_arb (
  input  logic       owner_host,
  input  logic       seq_valid,
  output logic       seq_ready,
  input  logic [7:0] seq_data,
  input  logic       seq_half,
  input  logic       host_valid,
  output logic       host_ready,
  input  logic       host_rs,
  input  logic [7:0] host_data,
  output logic       cmd_valid,
  input  logic       cmd_ready,
  output logic       cmd_rs,
  output logic [7:0] cmd_data,
  output logic       cmd_half
);

  always_comb begin
    if (owner_host) begin
      cmd_valid  = host_valid;
      cmd_rs     = host_rs;
      cmd_data   = host_data;
      cmd_half   = 1'b0;
      host_ready = cmd_ready;
      seq_ready  = 1'b0;
    end else begin
      cmd_valid  = seq_valid;
      cmd_rs     = 1'b0;
      cmd_data   = seq_data;
      cmd_half   = seq_half;
      host_ready = 1'b0;
      seq_ready  = cmd_ready;
    end
  end

endmodule

// File: rtl/lcd_init_seq.sv
module lcd_init_seq
  import lcd_init_pkg::*;
#(
  parameter bit          WIDTH4   = 1'b1,
  parameter int unsigned W_POWER  = 100_000,
  parameter int unsigned W_GAP1   = 250_000,
  parameter int unsigned W_GAP2   = 7_500,
  parameter int unsigned W_CMD    = 2_500,
  parameter int unsigned W_CLEAR  = 100_000,
  parameter int unsigned W_SETTLE = 250_000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_lines,
  input  logic       cfg_font,
  input  logic       cfg_incr,
  input  logic       cfg_shift,
  input  logic       host_valid,
  output logic       host_ready,
  input  logic       host_rs,
  input  logic [7:0] host_data,
  output logic       cmd_valid,
  input  logic       cmd_ready,
  output logic       cmd_rs,
  output logic [7:0] cmd_data,
  output logic       cmd_half,
  output logic       init_done
);

  localparam int unsigned W_MAX = max_of(max_of(max_of(W_POWER, W_GAP1), max_of(W_GAP2, W_CMD)),
                                         max_of(W_CLEAR, W_SETTLE));
  localparam int          CW    = $clog2(W_MAX + 1);
  localparam logic [CW-1:0] L_POWER = CW'(W_POWER - 1);

  phase_t        phase;
  step_t         step;
  step_t         step_nxt;
  lcd_cfg_t      cfg_q;
  lcd_cfg_t      cfg_in;
  logic [7:0]    op;
  logic          op_half;
  logic [CW-1:0] pause;
  logic          step_last;
  logic          tmr_load;
  logic          tmr_expired;
  logic          seq_valid;
  logic          seq_ready;

  assign cfg_in = '{lines: cfg_lines, font: cfg_font, incr: cfg_incr, shift: cfg_shift};

  lcd_init_steps #(
    .WIDTH4  (WIDTH4),
    .CW      (CW),
    .W_GAP1  (W_GAP1),
    .W_GAP2  (W_GAP2),
    .W_CMD   (W_CMD),
    .W_CLEAR (W_CLEAR),
    .W_SETTLE(W_SETTLE)
  ) u_steps (
    .idx     (step),
    .cfg     (cfg_q),
    .op      (op),
    .half    (op_half),
    .wait_val(pause),
    .last    (step_last),
    .nxt     (step_nxt)
  );

  assign seq_valid = (phase == PH_OFFER);
  assign tmr_load  = seq_valid && seq_ready;

  lcd_init_timer #(
    .CW   (CW),
    .START(L_POWER)
  ) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (tmr_load),
    .load_val(pause),
    .expired (tmr_expired)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_POWER;
      step  <= ST_WAKE_A;
      cfg_q <= '0;
    end else begin
      case (phase)
        PH_POWER: if (tmr_expired) begin
          phase <= PH_OFFER;
          cfg_q <= cfg_in;
        end
        PH_OFFER: if (seq_ready) phase <= PH_HOLD;
        PH_HOLD: if (tmr_expired) begin
          if (step_last) begin
            phase <= PH_READY;
          end else begin
            step  <= step_nxt;
            phase <= PH_OFFER;
          end
        end
        PH_READY: phase <= PH_READY;
        default:  phase <= PH_POWER;
      endcase
    end
  end

  assign init_done = (phase == PH_READY);

  lcd_init_arb u_arb (
    .owner_host(init_done),
    .seq_valid (seq_valid),
    .seq_ready (seq_ready),
    .seq_data  (op),
    .seq_half  (op_half),
    .host_valid(host_valid),
    .host_ready(host_ready),
    .host_rs   (host_rs),
    .host_data (host_data),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .cmd_rs    (cmd_rs),
    .cmd_data  (cmd_data),
    .cmd_half  (cmd_half)
  );

  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!init_done && cmd_valid && !cmd_ready) |=>
      (cmd_valid && $stable(cmd_data) && $stable(cmd_half))); // R7

  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> init_done); // R8

  AST_HOST_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    !init_done |-> !host_ready); // R9

  AST_INIT_RS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!init_done && cmd_valid) |-> !cmd_rs); // R11

  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != PH_POWER) |=> $stable(cfg_q)); // R6

  AST_HALF_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_half) |-> (cmd_data[3:0] == 4'h0)); // R3

  generate
    if (!WIDTH4) begin : g_wide_checks
      AST_WIDE_NO_HALF: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> !cmd_half); // R3
    end
  endgenerate

endmodule

// File: tb/sim_lcd_init_seq.sv
module sim_lane #(
  parameter bit WIDTH4 = 1'b1
) (
  input  logic clk,
  output logic finished,
  output int   n_run,
  output int   n_fail
);

  localparam int P_POWER  = 20;
  localparam int P_GAP1   = 15;
  localparam int P_GAP2   = 6;
  localparam int P_CMD    = 3;
  localparam int P_CLEAR  = 9;
  localparam int P_SETTLE = 12;
  localparam int LANE     = WIDTH4 ? 4 : 8;

  logic       rst_n;
  logic       cfg_lines, cfg_font, cfg_incr, cfg_shift;
  logic       exp_lines, exp_font, exp_incr, exp_shift;
  logic       host_valid, host_ready, host_rs;
  logic [7:0] host_data;
  logic       cmd_valid, cmd_ready, cmd_rs, cmd_half, init_done;
  logic [7:0] cmd_data;
  logic       ready_man, ready_pat, bp_en;
  int         m_run, m_fail, d_run, d_fail, pops;

  assign cmd_ready = bp_en ? ready_pat : ready_man;
  assign n_run  = m_run + d_run;
  assign n_fail = m_fail + d_fail;

  lcd_init_seq #(
    .WIDTH4  (WIDTH4),
    .W_POWER (P_POWER),
    .W_GAP1  (P_GAP1),
    .W_GAP2  (P_GAP2),
    .W_CMD   (P_CMD),
    .W_CLEAR (P_CLEAR),
    .W_SETTLE(P_SETTLE)
  ) u0 (
    .clk(clk), .rst_n(rst_n),
    .cfg_lines(cfg_lines), .cfg_font(cfg_font), .cfg_incr(cfg_incr), .cfg_shift(cfg_shift),
    .host_valid(host_valid), .host_ready(host_ready), .host_rs(host_rs), .host_data(host_data),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_rs(cmd_rs), .cmd_data(cmd_data),
    .cmd_half(cmd_half), .init_done(init_done)
  );

  typedef struct {
    logic [7:0] d;
    logic       half;
    int         gap;
    string      tag;
  } item_t;

  item_t exp_q[$];

  task automatic chk_m(bit ok, string tag, int act, int expv);
    m_run++;
    if (!ok) begin
      m_fail++;
      $display("FAIL %s (lane %0d): actual %0h expected %0h", tag, LANE, act, expv);
    end
  endtask

  task automatic chk_d(bit ok, string tag, int act, int expv);
    d_run++;
    if (!ok) begin
      d_fail++;
      $display("FAIL %s (lane %0d): actual %0h expected %0h", tag, LANE, act, expv);
    end
  endtask

  task automatic push(logic [7:0] d, logic h, int g, string tag);
    item_t it;
    it.d = d; it.half = h; it.gap = g; it.tag = tag;
    exp_q.push_back(it);
  endtask

  // Expected stream, built from the requirements and the latched expectation.
  task automatic rebuild();
    logic [7:0] fs, em;
    exp_q.delete();
    fs = 8'h20 | (WIDTH4 ? 8'h00 : 8'h10) | {4'b0, exp_lines, 3'b0} | {5'b0, exp_font, 2'b0};
    em = 8'h04 | {6'b0, exp_incr, exp_shift};
    push(8'h30, WIDTH4, P_POWER, "R1 R10 power wait / first wake");
    push(8'h30, WIDTH4, P_GAP1,  "R2 second wake");
    push(8'h30, WIDTH4, P_GAP2,  "R2 third wake");
    if (WIDTH4) push(8'h20, 1'b1, P_CMD, "R3 width switch");
    push(fs,    1'b0, P_CMD,   "R4 function set");
    push(8'h08, 1'b0, P_CMD,   "R5 display off");
    push(8'h01, 1'b0, P_CMD,   "R5 clear");
    push(em,    1'b0, P_CLEAR, "R5 entry mode");
    push(8'h0C, 1'b0, P_CMD,   "R5 display on");
  endtask

  // Monitor / scoreboard
  initial begin : monitor
    int idle;
    bit seen, done_seen, hold_prev;
    logic [7:0] d_prev;
    logic h_prev;
    item_t it;
    m_run = 0; m_fail = 0; pops = 0;
    idle = 0; seen = 0; done_seen = 0; hold_prev = 0; d_prev = '0; h_prev = 1'b0;
    forever begin
      @(negedge clk);
      if (!rst_n) begin
        rebuild();
        idle = 0; seen = 0; done_seen = 0; hold_prev = 0;
      end else if (!done_seen) begin
        if (init_done) begin
          chk_m(idle == P_SETTLE, "R8 settle pause", idle, P_SETTLE);
          chk_m(exp_q.size() == 0, "R5 whole sequence sent", exp_q.size(), 0);
          done_seen = 1;
        end else begin
          if (host_valid) chk_m(!host_ready, "R9 host blocked", host_ready, 0);
          if (hold_prev)
            chk_m(cmd_valid && cmd_data == d_prev && cmd_half == h_prev,
                  "R7 stalled command held", cmd_data, d_prev);
          if (cmd_valid && !seen) begin
            seen = 1;
            if (exp_q.size() == 0) chk_m(0, "R5 unexpected command", cmd_data, 0);
            else chk_m(idle == exp_q[0].gap, exp_q[0].tag, idle, exp_q[0].gap);
          end
          hold_prev = cmd_valid && !cmd_ready;
          d_prev = cmd_data; h_prev = cmd_half;
          if (cmd_valid && cmd_ready) begin
            if (exp_q.size() != 0) begin
              it = exp_q.pop_front();
              chk_m(cmd_data == it.d, it.tag, cmd_data, it.d);
              chk_m(cmd_half == it.half, it.tag, cmd_half, it.half);
              chk_m(!cmd_rs, "R11 instruction select", cmd_rs, 0);
            end
            pops++;
            idle = 0; seen = 0;
          end else if (!cmd_valid) begin
            idle++;
          end
        end
      end
    end
  end

  // Back-pressure pattern
  initial begin : bp_gen
    int k;
    k = 0; ready_pat = 1'b1;
    forever begin
      @(posedge clk); #1;
      ready_pat = ((k % 4) != 1) && ((k % 7) != 3);
      k++;
    end
  end

  task automatic start(logic l, logic f, logic i, logic s, string tag);
    @(posedge clk); #1;
    rst_n = 1'b0;
    cfg_lines = l; cfg_font = f; cfg_incr = i; cfg_shift = s;
    exp_lines = l; exp_font = f; exp_incr = i; exp_shift = s;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk_d(!cmd_valid, {tag, " reset: cmd_valid"}, cmd_valid, 0);
    chk_d(!init_done, {tag, " reset: init_done"}, init_done, 0);
    chk_d(!host_ready, {tag, " reset: host_ready"}, host_ready, 0);
    @(posedge clk); #1;
    rst_n = 1'b1;
  endtask

  task automatic wait_done(string tag);
    for (int c = 0; c < 2000 && !init_done; c++) @(negedge clk);
    chk_d(init_done, tag, init_done, 1);
  endtask

  // Driver
  initial begin : driver
    int base;
    d_run = 0; d_fail = 0; finished = 1'b0;
    rst_n = 1'b0; ready_man = 1'b1; bp_en = 1'b0;
    host_valid = 1'b0; host_rs = 1'b0; host_data = 8'h00;
    cfg_lines = 0; cfg_font = 0; cfg_incr = 0; cfg_shift = 0;
    exp_lines = 0; exp_font = 0; exp_incr = 0; exp_shift = 0;

    // Run 1: back-pressure, host knocking, configuration changed mid-way (R6, R9)
    start(1'b1, 1'b0, 1'b1, 1'b0, "R1");
    bp_en = 1'b1;
    host_valid = 1'b1; host_rs = 1'b1; host_data = 8'hAA;
    for (int c = 0; c < 200 && !cmd_valid; c++) @(negedge clk);
    @(posedge clk); #1;
    cfg_lines = 1'b0; cfg_font = 1'b1; cfg_incr = 1'b0; cfg_shift = 1'b1;  // R6: must be ignored
    host_valid = 1'b0;
    wait_done("R8 init_done reached");
    bp_en = 1'b0;
    repeat (5) @(negedge clk);
    chk_d(init_done, "R8 init_done stays high", init_done, 1);

    // Pass-through after start-up (R9)
    @(posedge clk); #1;
    host_valid = 1'b1; host_rs = 1'b1; host_data = 8'h41; ready_man = 1'b1;
    @(negedge clk);
    chk_d(cmd_valid, "R9 host valid forwarded", cmd_valid, 1);
    chk_d(cmd_data == 8'h41, "R9 host data forwarded", cmd_data, 8'h41);
    chk_d(cmd_rs, "R9 host rs forwarded", cmd_rs, 1);
    chk_d(!cmd_half, "R9 host items whole byte", cmd_half, 0);
    chk_d(host_ready, "R9 host_ready follows cmd_ready high", host_ready, 1);
    @(posedge clk); #1;
    ready_man = 1'b0; host_rs = 1'b0; host_data = 8'h0F;
    @(negedge clk);
    chk_d(!host_ready, "R9 host_ready follows cmd_ready low", host_ready, 0);
    chk_d(!cmd_rs && cmd_data == 8'h0F, "R9 host instruction forwarded", cmd_data, 8'h0F);
    @(posedge clk); #1;
    host_valid = 1'b0; ready_man = 1'b1;
    @(negedge clk);
    chk_d(!cmd_valid, "R9 idle host leaves port idle", cmd_valid, 0);

    // Run 2: interrupted by reset after a few commands, then restarted (R10)
    start(1'b0, 1'b1, 1'b0, 1'b1, "R1");
    bp_en = 1'b1;
    base = pops;
    for (int c = 0; c < 500 && pops < base + 4; c++) @(negedge clk);
    chk_d(!init_done, "R10 interrupted before completion", init_done, 0);
    start(1'b1, 1'b1, 1'b1, 1'b1, "R10");
    wait_done("R10 restarted sequence completes");
    bp_en = 1'b0;
    repeat (3) @(negedge clk);
    finished = 1'b1;
  end

endmodule

module sim_lcd_init_seq;

  logic clk;
  logic fin_n, fin_w;
  int   run_n, fail_n, run_w, fail_w, wd_fail;

  sim_lane #(.WIDTH4(1'b1)) lane_n (.clk(clk), .finished(fin_n), .n_run(run_n), .n_fail(fail_n));
  sim_lane #(.WIDTH4(1'b0)) lane_w (.clk(clk), .finished(fin_w), .n_run(run_w), .n_fail(fail_w));

  initial begin
    clk = 1'b0;
    forever #5 clk = ~clk;
  end

  initial begin
    wd_fail = 0;
    for (int c = 0; c < 100000 && !(fin_n && fin_w); c++) @(posedge clk);
    if (!(fin_n && fin_w)) begin
      wd_fail = 1;
      $display("FAIL watchdog: actual 0 expected 1 (run did not finish)");
    end
    $display("[TB] %0d tests run, %0d failed", run_n + run_w + wd_fail, fail_n + fail_w + wd_fail);
    $finish;
  end

endmodule